// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for every cycle of a synchronous burst memory. Two start strobes are accepted, one from the processor side and one from the controller side. Either strobe captures an external address. After that, an advance input walks the two least significant address bits through a four-beat burst.

A static order-select input chooses between two orders for the low bits. Linear order is a wrapping increment. Interleaved order XORs the start bits with the beat number. The upper address bits are held exactly as they were loaded. The block also reports the current beat number.

Bursts are optional: a fresh address may be loaded on every clock with no idle cycle. All address and burst control inputs are sampled on the rising clock edge. The outputs come from registers and so show the new value in the cycle after the sampling edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, addrOut is 0 and beatIdx is 0.
- R2: At a rising edge where procStrobe or ctrlStrobe is 1, addrIn is captured. From the next cycle, addrOut equals that address and beatIdx is 0.
- R3: At a rising edge with both strobes 0 and advance 1, beatIdx becomes (beatIdx + 1) mod 4. After beat 3 it wraps to 0.
- R4: With interleaveMode = 0 (linear order), addrOut[1:0] = (s + beatIdx) mod 4, where s is the loaded addrIn[1:0].
- R5: With interleaveMode = 1 (interleaved order), addrOut[1:0] = s XOR beatIdx.
- R6: At a rising edge with both strobes 0 and advance 0, addrOut and beatIdx keep their values.
- R7: When a strobe and advance are both 1 at the same edge, the strobe wins. The new address is loaded and beatIdx is 0.
- R8: addrOut[ADDR_W-1:2] changes only on a load. Advancing past beat 3 never carries into these bits.
- R9: Loads on consecutive cycles each take effect in the following cycle, with no lost or delayed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| procStrobe | input | 1 | Processor-side start strobe |
| ctrlStrobe | input | 1 | Controller-side start strobe |
| advance | input | 1 | Step to the next beat of the burst |
| interleaveMode | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addrIn | input | ADDR_W | External start address |
| addrOut | output | ADDR_W | Current word address |
| beatIdx | output | 2 | Current beat number, 0 to 3 |

## Verification
The assertions assume that interleaveMode holds still across an edge whenever they compare addrOut between cycles. The order select is treated as static, so only the registered burst state is checked for stability directly. The stimulus changes the order select only in a few separate phases, and each phase starts with a fresh load. Strobes, advance and addresses are otherwise driven from a pseudo-random sequence with directed stretches. These stretches cover strobe-and-advance collisions, back-to-back loads, long idle holds and advance runs beyond four beats.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic load;
    logic step;
  } burst_strobes_t;
endpackage

// File: rtl/burst_control.sv
module burst_control
  import burst_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           procStrobe,
  input  logic           ctrlStrobe,
  input  logic           advance,
  output burst_strobes_t strb
);
  logic anyStrobe;

  always_comb begin
    anyStrobe = procStrobe | ctrlStrobe;
    strb.load = anyStrobe;
    strb.step = advance & ~anyStrobe;
  end

  // R7: loading and stepping never happen in the same cycle
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step}));

  // R7: a strobe that arrives together with advance still loads
  assert_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    (advance && (procStrobe || ctrlStrobe)) |-> strb.load);
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  burst_strobes_t    strb,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BEAT_W-1:0] beatIdx
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upperQ;
  logic [BEAT_W-1:0] startLowQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] lowLinear;
  logic [BEAT_W-1:0] lowInter;
  logic [BEAT_W-1:0] lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ    <= '0;
      startLowQ <= '0;
      beatQ     <= '0;
    end else if (strb.load) begin
      upperQ    <= addrIn[ADDR_W-1:BEAT_W];
      startLowQ <= addrIn[BEAT_W-1:0];
      beatQ     <= '0;
    end else if (strb.step) begin
      beatQ     <= beatQ + 1'b1;
    end
  end

  assign lowLinear = startLowQ + beatQ;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_inter
    assign lowInter[i] = startLowQ[i] ^ beatQ[i];
  end

  assign lowSel  = interleaveMode ? lowInter : lowLinear;
  assign addrOut = {upperQ, lowSel};
  assign beatIdx = beatQ;

  // R2: a load shows the captured address at beat 0
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (addrOut == $past(addrIn)) && (beatIdx == '0));

  // R3: a step moves the beat on by one, modulo four
  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> beatIdx == BEAT_W'($past(beatIdx) + 1));

  // R6: with no load and no step the burst state is held
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> ($stable(beatIdx) && $stable(upperQ) && $stable(startLowQ)));

  // R8: only a load may alter the upper address bits
  assert_no_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(addrOut[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        beatIdx
);
  burst_strobes_t strb;

  burst_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .strb       (strb)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .interleaveMode (interleaveMode),
    .addrIn         (addrIn),
    .addrOut        (addrOut),
    .beatIdx        (beatIdx)
  );
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int WATCHDOG = 20000;

  logic clk = 0;
  logic rstN = 0;
  logic procStrobe = 0, ctrlStrobe = 0, advance = 0, interleaveMode = 0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic [1:0] beatIdx;

  int nCmp = 0, nBad = 0, cycles = 0;
  bit done = 0;

  // reference state
  int mUpper = 0, mStart = 0, mBeat = 0;
  string beatTag = "R1";
  logic [31:0] lfsr = 32'h1ACE_B00C;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .advance(advance), .interleaveMode(interleaveMode), .addrIn(addrIn),
    .addrOut(addrOut), .beatIdx(beatIdx));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mUpper = 0; mStart = 0; mBeat = 0; beatTag = "R1";
    end else if (procStrobe || ctrlStrobe) begin
      mUpper = int'(addrIn) / 4; mStart = int'(addrIn) % 4; mBeat = 0;
      beatTag = advance ? "R7" : "R2";
    end else if (advance) begin
      mBeat = (mBeat + 1) % 4; beatTag = "R3";
    end else begin
      beatTag = "R6";
    end
  end

  task automatic cmp(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkNow();
    int low;
    low = interleaveMode ? (mStart ^ mBeat) : ((mStart + mBeat) % 4);
    cmp(beatTag, int'(beatIdx), mBeat);
    cmp(interleaveMode ? "R5" : "R4", int'(addrOut[1:0]), low);
    cmp("R8", int'(addrOut[AW-1:2]), mUpper);
  endtask

  function automatic logic [31:0] nextRand(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  // one cycle: check current outputs, then drive inputs for next edge
  task automatic cyc(bit p, bit c, bit a, logic [AW-1:0] ad);
    @(negedge clk);
    checkNow();
    procStrobe = p; ctrlStrobe = c; advance = a; addrIn = ad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", int'(addrOut), 0);
    cmp("R1", int'(beatIdx), 0);
    rstN = 1;
    @(negedge clk);
    cmp("R1", int'(addrOut), 0);

    for (int m = 0; m < 2; m++) begin
      interleaveMode = m[0];
      // start values 0..3, burst past four beats (R3, R8 wrap)
      for (int s = 0; s < 4; s++) begin
        cyc(1, 0, 0, AW'(32'h3FFFC + s));
        for (int k = 0; k < 6; k++) cyc(0, 0, 1, '0);
        cyc(0, 0, 0, '0);
        cyc(0, 0, 0, '0);              // R6 hold
      end
      // R7 collision using controller strobe
      cyc(0, 1, 1, AW'(32'h12346));
      cyc(0, 0, 1, '0);
      cyc(1, 0, 1, AW'(32'h55551));
      // R9 back-to-back loads on alternating strobes
      for (int k = 0; k < 8; k++) cyc(k[0], ~k[0], 0, AW'(32'h0A0A0 + k * 37));
      cyc(0, 0, 0, '0);
    end

    interleaveMode = 0;
    cyc(1, 0, 0, AW'(32'h00011));
    for (int k = 0; k < 2000; k++) begin
      if (k == 1000) begin
        cyc(1, 1, 0, AW'(lfsr));       // fresh load before mode change
        @(negedge clk);
        checkNow();
        interleaveMode = 1;
        procStrobe = 1; ctrlStrobe = 0; advance = 0; addrIn = AW'(lfsr >> 3);
      end
      lfsr = nextRand(lfsr);
      cyc(lfsr[0] & lfsr[5], lfsr[9] & lfsr[3] & lfsr[1], lfsr[13] | lfsr[7], AW'(lfsr >> 4));
    end
    cyc(0, 0, 0, '0);
    @(negedge clk);
    checkNow();
    done = 1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule